// File: doc/BRIEF.md
# Programmable CRC Accumulator Peripheral

This block is a register-mapped checksum engine that sits on a simple 32-bit bus with address, write enable, write data and read data. Software first programs a start value and a generator polynomial, then sets a reload bit in the control register. The accumulator then takes the start value. After that, every 32-bit word written to the data register is folded into the running remainder in a single clock. A read of the data register returns the remainder at any time.

Control bits choose how the incoming word's bits are mirrored before folding: not at all, within each byte, within each halfword, or across the whole word. A further bit mirrors the result on readback. With whole-word input mirroring and output mirroring both on, one MSB-first engine produces the reflected checksums in common use, including CRC-32 and CRC-32C. In that case software writes the polynomial and start value in mirrored form. The engine applies no final inversion; software complements the result itself.

Top module: `crc32_prog_unit`

## Requirements
- R1: After hardware reset, the data register (offset 0x00) reads 0xFFFFFFFF, control (0x08) reads 0, start value (0x10) reads 0xFFFFFFFF and polynomial (0x14) reads 0x04C11DB7.
- R2: The start value and polynomial registers read back exactly what was written. An access to any other offset (for example 0x04) reads 0, and a write there changes no register.
- R3: Writing control with bit 0 set loads the accumulator from the start value register at that clock edge. Bit 0 always reads back 0, bits 7:5 read back as written, and all other control bits read 0.
- R4: A write to the data register folds the 32-bit word into the accumulator in one clock, MSB first. The polynomial is held in normal form without the x^32 term. The next read of the data register returns the new remainder.
- R5: Control bits 6:5 select input mirroring. 00 leaves the word as is, 01 mirrors bits within each byte, 10 within each halfword, and 11 across the whole word.
- R6: With control bit 7 set, a read of the data register returns the accumulator with its 32 bits mirrored. With bit 7 clear, the accumulator is returned as is.
- R7: A read of the data register right after a reload returns the start value, mirrored if bit 7 is set, before any word is written.
- R8: Data words written on consecutive clock cycles are each folded in turn with no stall. A data write in the cycle right after a reload folds into the reloaded value.
- R9: With control 0xE1, the mirrored polynomial and the mirrored start value 0xFFFFFFFF, the result matches a bytewise reflected CRC. This holds both for the reflected constant 0xEDB88320 and for 0x82F63B78, with bytes supplied little-endian within each word.
- R10: No final inversion is applied. The value read is the raw remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset of the register accessed |
| we | input | 1 | Write strobe, one word per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |

## Verification
The hardest situations to reach are those where timing and configuration interact. Examples are a data word in the cycle right after a reload, several words on consecutive cycles, and a change of input mirroring partway through a stream. The bench drives writes on back-to-back cycles with no idle gap. It switches the control field between words and compares each remainder against a bitwise software model. That model is written MSB-first per bit for the plain modes and LSB-first per byte for the reflected checksums. The reflected runs use the nine-character check string padded with zeros to three words.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int CRC_W  = 32;
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_DATA = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL = 5'h08;
    localparam logic [REG_AW-1:0] OFS_INIT = 5'h10;
    localparam logic [REG_AW-1:0] OFS_POLY = 5'h14;

    localparam int CTL_RELOAD = 0;
    localparam int CTL_IN_LO  = 5;
    localparam int CTL_IN_HI  = 6;
    localparam int CTL_OUTREV = 7;

    localparam logic [CRC_W-1:0] INIT_RST = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] POLY_RST = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        IN_KEEP = 2'b00,
        IN_BYTE = 2'b01,
        IN_HALF = 2'b10,
        IN_WORD = 2'b11
    } in_rev_e;

    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] init;
        logic [CRC_W-1:0] poly;
        in_rev_e          in_rev;
        logic             out_rev;
    } crc_regs_t;
endpackage

// File: rtl/crc_lane_mirror.sv
module crc_lane_mirror #(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NLANE = W / LANE;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        for (genvar b = 0; b < LANE; b++) begin : g_bit
            assign dout[l*LANE + b] = din[l*LANE + LANE - 1 - b];
        end
    end
endmodule

// File: rtl/crc_word_fold.sv
module crc_word_fold #(
    parameter int W = 32
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] poly,
    input  logic [W-1:0] word,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] work;

    always_comb begin
        work = crc_in ^ word;
        for (int i = 0; i < W; i++) begin
            if (work[W-1]) begin
                work = (work << 1) ^ poly;
            end else begin
                work = work << 1;
            end
        end
        crc_out = work;
    end
endmodule

// File: rtl/crc32_prog_unit.sv
module crc32_prog_unit
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              we,
    input  logic [CRC_W-1:0]  wdata,
    output logic [CRC_W-1:0]  rdata
);
    localparam int CTL_PAD = CRC_W - CTL_OUTREV - 1;

    crc_regs_t r_q;
    crc_regs_t r_d;

    logic wr_data;
    logic wr_ctrl;
    logic wr_init;
    logic wr_poly;

    assign wr_data = we && (addr == OFS_DATA);
    assign wr_ctrl = we && (addr == OFS_CTRL);
    assign wr_init = we && (addr == OFS_INIT);
    assign wr_poly = we && (addr == OFS_POLY);

    // Input mirroring variants, one per granularity
    logic [CRC_W-1:0] din_byte;
    logic [CRC_W-1:0] din_half;
    logic [CRC_W-1:0] din_word;
    logic [CRC_W-1:0] din_sel;
    logic [CRC_W-1:0] acc_mirror;
    logic [CRC_W-1:0] acc_fold_d;

    crc_lane_mirror #(.W(CRC_W), .LANE(8))      u_mir_byte (.din(wdata),   .dout(din_byte));
    crc_lane_mirror #(.W(CRC_W), .LANE(16))     u_mir_half (.din(wdata),   .dout(din_half));
    crc_lane_mirror #(.W(CRC_W), .LANE(CRC_W))  u_mir_word (.din(wdata),   .dout(din_word));
    crc_lane_mirror #(.W(CRC_W), .LANE(CRC_W))  u_mir_out  (.din(r_q.acc), .dout(acc_mirror));

    always_comb begin
        unique case (r_q.in_rev)
            IN_BYTE: din_sel = din_byte;
            IN_HALF: din_sel = din_half;
            IN_WORD: din_sel = din_word;
            default: din_sel = wdata;
        endcase
    end

    crc_word_fold #(.W(CRC_W)) u_fold (
        .crc_in  (r_q.acc),
        .poly    (r_q.poly),
        .word    (din_sel),
        .crc_out (acc_fold_d)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.in_rev  = in_rev_e'(wdata[CTL_IN_HI:CTL_IN_LO]);
            r_d.out_rev = wdata[CTL_OUTREV];
            if (wdata[CTL_RELOAD]) begin
                r_d.acc = r_q.init;
            end
        end
        if (wr_init) r_d.init = wdata;
        if (wr_poly) r_d.poly = wdata;
        if (wr_data) r_d.acc  = acc_fold_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{acc: INIT_RST, init: INIT_RST, poly: POLY_RST,
                     in_rev: IN_KEEP, out_rev: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_DATA: rdata = r_q.out_rev ? acc_mirror : r_q.acc;
            OFS_CTRL: rdata = {{CTL_PAD{1'b0}}, r_q.out_rev, r_q.in_rev, {CTL_IN_LO{1'b0}}};
            OFS_INIT: rdata = r_q.init;
            OFS_POLY: rdata = r_q.poly;
            default:  rdata = '0;
        endcase
    end

    // R3: a reload takes the start value at the edge
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTL_RELOAD]) |=> (r_q.acc == $past(r_q.init)));

    // R4: the accumulator moves only on a data write or a reload
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data || (wr_ctrl && wdata[CTL_RELOAD])) |=> $stable(r_q.acc));

    // R2: register writes land unaltered
    a_r2_init_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_init |=> (r_q.init == $past(wdata)));

    a_r2_poly_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_poly |=> (r_q.poly == $past(wdata)));

    // R2: unmapped offsets leave configuration untouched
    a_r2_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(wr_data || wr_ctrl || wr_init || wr_poly)) |=>
            ($stable(r_q.init) && $stable(r_q.poly) && $stable(r_q.out_rev)));
endmodule

// File: tb/crc32_prog_unit_tb.sv
module crc32_prog_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] A_DATA = 5'h00;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_INIT = 5'h10;
    localparam logic [4:0] A_POLY = 5'h14;

    always #2 clk = ~clk;

    crc32_prog_unit u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] rev_bytes(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[(i/8)*8 + 7 - (i%8)];
        return r;
    endfunction

    function automatic logic [31:0] rev_halves(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[(i/16)*16 + 15 - (i%16)];
        return r;
    endfunction

    // serial MSB-first reference, one data bit at a time
    function automatic logic [31:0] ref_msb(input logic [31:0] c, input logic [31:0] p,
                                            input logic [31:0] w);
        logic fb;
        for (int b = 31; b >= 0; b--) begin
            fb = c[31] ^ w[b];
            c  = c << 1;
            if (fb) c = c ^ p;
        end
        return c;
    endfunction

    // reflected reference, bytes LSB first
    function automatic logic [31:0] ref_refl(input logic [31:0] c, input logic [31:0] rp,
                                             input logic [7:0] d);
        c = c ^ {24'h0, d};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1;
        v = rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(A_DATA, v); check("R1 data", v, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_INIT, v); check("R1 init", v, 32'hFFFF_FFFF);
        rd(A_POLY, v); check("R1 poly", v, 32'h04C1_1DB7);
    endtask

    task automatic t_reg_map();
        logic [31:0] v;
        wr(A_INIT, 32'hA5A5_0F0F); rd(A_INIT, v); check("R2 init readback", v, 32'hA5A5_0F0F);
        wr(A_POLY, 32'h1EDC_6F41); rd(A_POLY, v); check("R2 poly readback", v, 32'h1EDC_6F41);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, v);  check("R2 unmapped read", v, 32'h0);
        rd(A_INIT, v); check("R2 unmapped no init change", v, 32'hA5A5_0F0F);
        rd(A_POLY, v); check("R2 unmapped no poly change", v, 32'h1EDC_6F41);
        rd(A_CTRL, v); check("R2 unmapped no ctrl change", v, 32'h0);
        rd(A_DATA, v); check("R2 unmapped no data change", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(A_INIT, 32'h1234_5678);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R3 ctrl readback", v, 32'h0000_00E0);
        rd(A_DATA, v); check("R7 mirrored start after reload", v, rev32(32'h1234_5678));
        wr(A_CTRL, 32'h0000_0001);
        rd(A_CTRL, v); check("R3 reload bit self clears", v, 32'h0);
        rd(A_DATA, v); check("R7 plain start after reload", v, 32'h1234_5678);
        wr(A_CTRL, 32'h0000_0060);
        rd(A_DATA, v); check("R3 no reload without bit0", v, 32'h1234_5678);
    endtask

    task automatic t_plain_fold();
        logic [31:0] v, m;
        logic [31:0] pats [3] = '{32'hDEAD_BEEF, 32'h0000_0000, 32'h8000_0001};
        wr(A_POLY, 32'h04C1_1DB7);
        wr(A_INIT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0000_0001);
        m = 32'hFFFF_FFFF;
        foreach (pats[i]) begin
            wr(A_DATA, pats[i]);
            m = ref_msb(m, 32'h04C1_1DB7, pats[i]);
            rd(A_DATA, v); check("R4 fold one word", v, m);
        end
        check("R10 raw remainder, not inverted", v, m);
        wr(A_POLY, 32'h1EDC_6F41);
        wr(A_INIT, 32'h0000_0000);
        wr(A_CTRL, 32'h0000_0001);
        wr(A_DATA, 32'h0000_0001);
        rd(A_DATA, v); check("R4 other poly", v, ref_msb(32'h0, 32'h1EDC_6F41, 32'h0000_0001));
    endtask

    task automatic t_in_rev();
        logic [31:0] v, m;
        logic [31:0] w = 32'h1357_9BDF;
        wr(A_POLY, 32'h04C1_1DB7);
        wr(A_INIT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0000_0021);
        wr(A_DATA, w);
        m = ref_msb(32'hFFFF_FFFF, 32'h04C1_1DB7, rev_bytes(w));
        rd(A_DATA, v); check("R5 byte mirror", v, m);
        wr(A_CTRL, 32'h0000_0040);
        wr(A_DATA, w);
        m = ref_msb(m, 32'h04C1_1DB7, rev_halves(w));
        rd(A_DATA, v); check("R5 halfword mirror mid stream", v, m);
        wr(A_CTRL, 32'h0000_0060);
        wr(A_DATA, w);
        m = ref_msb(m, 32'h04C1_1DB7, rev32(w));
        rd(A_DATA, v); check("R5 word mirror", v, m);
        wr(A_CTRL, 32'h0000_0080);
        rd(A_DATA, v); check("R6 output mirror on", v, rev32(m));
        wr(A_CTRL, 32'h0000_0000);
        rd(A_DATA, v); check("R6 output mirror off", v, m);
    endtask

    task automatic t_burst();
        logic [31:0] v, m;
        logic [31:0] ws [4] = '{32'h0102_0304, 32'hFFFF_0000, 32'h55AA_55AA, 32'h7000_000E};
        wr(A_POLY, 32'h04C1_1DB7);
        wr(A_INIT, 32'hCAFE_F00D);
        @(negedge clk);
        addr = A_CTRL; wdata = 32'h0000_0001; we = 1'b1;
        m = 32'hCAFE_F00D;
        foreach (ws[i]) begin
            @(negedge clk);
            addr = A_DATA; wdata = ws[i]; we = 1'b1;
            m = ref_msb(m, 32'h04C1_1DB7, ws[i]);
        end
        @(negedge clk);
        we = 1'b0;
        rd(A_DATA, v); check("R8 back to back after reload", v, m);
    endtask

    task automatic t_reflected(input string tag, input logic [31:0] rpoly);
        logic [31:0] v, m;
        logic [7:0] msg [12] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36,
                                 8'h37, 8'h38, 8'h39, 8'h00, 8'h00, 8'h00};
        wr(A_POLY, rev32(rpoly));
        wr(A_INIT, rev32(32'hFFFF_FFFF));
        wr(A_CTRL, 32'h0000_00E1);
        rd(A_DATA, v); check({"R7 reflected start ", tag}, v, 32'hFFFF_FFFF);
        m = 32'hFFFF_FFFF;
        for (int i = 0; i < 3; i++) begin
            wr(A_DATA, {msg[4*i+3], msg[4*i+2], msg[4*i+1], msg[4*i]});
            for (int k = 0; k < 4; k++) m = ref_refl(m, rpoly, msg[4*i+k]);
            rd(A_DATA, v); check({"R9 reflected ", tag}, v, m);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_reg_map();
        t_ctrl();
        t_plain_fold();
        t_in_rev();
        t_burst();
        t_reflected("crc32", 32'hEDB8_8320);
        t_reflected("crc32c", 32'h82F6_3B78);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule